// File: doc/BRIEF.md
# Serial Line Code Encoder/Decoder

This block sits between a serial bit stream and the wire of one channel. It encodes outgoing data into a line code and decodes incoming line samples back into data bits. A single mode input picks the code at run time. The choices are two level codes: plain NRZ and NRZI. There are also three biphase codes, which change the line at half-bit points: FM0, FM1 and Manchester. The whole block runs on one clock, which is the oversampling clock (OVS samples per bit cell, 16 by default).

On the transmit side, each pulse of `tx_stb` starts a new bit cell carrying `tx_bit`. The line level for the cell's first half is registered on that edge. For biphase codes, the second-half level is applied OVS/2 clocks later.

On the receive side, the level codes are sampled on the caller's `rx_stb`. The biphase codes are timed by the decoder itself. It locks onto transitions, samples part way into the cell, and flags cells that lack a mandatory transition. The mode is meant to change only while reset is held. After reset the line idles high.

Top module: `line_codec`

## Requirements
- R1: With mode 0 (and any unused code 5 to 7), plain NRZ applies: on a `tx_stb` edge, `tx_line` takes `tx_bit` for the whole cell. On an `rx_stb` edge, `rx_data` takes `rx_in`.
- R2: With mode 1 (NRZI), a data 0 toggles `tx_line` at the strobe and a data 1 leaves it unchanged. The decoder reports 1 when the sampled level equals the previous sampled level, and 0 otherwise. The reference level after reset is high.
- R3: With mode 2 (FM0), the line toggles at every cell start, and toggles again at mid-cell for a data 0. The decoder reports 0 when the level at its mid sample differs from the level after the cell's start edge.
- R4: With mode 3 (FM1), the line toggles at every cell start, and toggles again at mid-cell for a data 1. The decoder reports 1 when a mid-cell change is seen.
- R5: With mode 4 (Manchester), a 1 is sent high then low and a 0 is sent low then high. The decoder emits the bit on the mid-cell edge: 1 if the line is now low. It locks on the first edge after idle, so a stream leaving a high idle line opens with a 1.
- R6: After reset `tx_line` is high, and it keeps its level while no `tx_stb` arrives.
- R7: The first-half level is visible right after the strobe edge. For biphase codes the second-half level appears exactly OVS/2 clocks after the strobe edge.
- R8: The biphase decoder counts samples from the last accepted edge. It accepts an edge as a cell edge when it is unlocked, or when the count has reached MID_SAMPLE (12). Earlier edges do not move its timing. For FM codes it samples the mid-cell level when the count equals MID_SAMPLE and raises `rx_valid` one clock later.
- R9: When a locked biphase decoder sees no accepted edge by a count of OVS+4, it pulses `rx_viol` for one clock and unlocks. `rx_valid` and `rx_viol` are never high together. An unlocked decoder never flags.
- R10: `rx_valid` rises one clock after a sampling event. In biphase modes `rx_stb` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode | input | 3 | Code select: 0 NRZ, 1 NRZI, 2 FM0, 3 FM1, 4 Manchester |
| tx_stb | input | 1 | Start of a transmit bit cell |
| tx_bit | input | 1 | Data bit for the cell being started |
| tx_line | output | 1 | Encoded line output |
| rx_in | input | 1 | Sampled line input |
| rx_stb | input | 1 | Bit-time sample strobe for the level codes |
| rx_valid | output | 1 | One-clock pulse: `rx_data` holds a decoded bit |
| rx_data | output | 1 | Decoded data bit |
| rx_viol | output | 1 | One-clock pulse: biphase cell missing its mandatory transition |

## Verification
The bench loops the encoder into the decoder for every code. It checks the line level at the first clock of each cell and on both sides of the half-bit point, so an encoder that moves its mid-cell change by a single clock, or mixes up the FM0/FM1 polarity, fails at once.

A forced line drives a biphase cell whose mid-cell edge would pull the phase if it were accepted, followed by an early cell edge. A decoder that resynchronises on mid-cell edges, or that rejects edges arriving slightly early, decodes the wrong bits.

A lone edge followed by silence pins the exact clock of the violation pulse. Strobing `rx_stb` on a quiet line in FM mode catches a decoder that lets the level-code strobe or an unlocked timeout leak into the biphase path.

// File: rtl/line_codec.sv
module line_codec #(
  parameter int OVS        = 16,
  parameter int MID_SAMPLE = 12,
  parameter int SLACK      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       tx_stb,
  input  logic       tx_bit,
  output logic       tx_line,
  input  logic       rx_in,
  input  logic       rx_stb,
  output logic       rx_valid,
  output logic       rx_data,
  output logic       rx_viol
);
  localparam int HALF = OVS / 2;
  localparam int TMO  = OVS + SLACK;
  localparam int CW   = $clog2(TMO + 1);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [CW-1:0] MID_C  = CW'(MID_SAMPLE);
  localparam logic [CW-1:0] TMO_C  = CW'(TMO);

  localparam logic [2:0] M_NRZ  = 3'd0;
  localparam logic [2:0] M_NRZI = 3'd1;
  localparam logic [2:0] M_FM0  = 3'd2;
  localparam logic [2:0] M_FM1  = 3'd3;
  localparam logic [2:0] M_MAN  = 3'd4;

  wire is_nrzi = (mode == M_NRZI);
  wire is_fm0  = (mode == M_FM0);
  wire is_fm1  = (mode == M_FM1);
  wire is_man  = (mode == M_MAN);
  wire is_fm   = is_fm0 | is_fm1;
  wire biphase = is_fm | is_man;

  // transmit
  logic [CW-1:0] tcnt;
  logic          tmid_pend;
  logic          tbit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_line   <= 1'b1;
      tcnt      <= '0;
      tmid_pend <= 1'b0;
      tbit_q    <= 1'b0;
    end else if (tx_stb) begin
      tbit_q    <= tx_bit;
      tcnt      <= CW'(1);
      tmid_pend <= biphase;
      if (is_nrzi)      tx_line <= tx_bit ? tx_line : ~tx_line;
      else if (is_fm)   tx_line <= ~tx_line;
      else              tx_line <= tx_bit;
    end else if (tmid_pend) begin
      if (tcnt == HALF_C) begin
        tmid_pend <= 1'b0;
        if (is_man)                      tx_line <= ~tbit_q;
        else if (is_fm0 && !tbit_q)      tx_line <= ~tx_line;
        else if (is_fm1 &&  tbit_q)      tx_line <= ~tx_line;
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  // receive
  logic          rx_q;
  logic          locked;
  logic [CW-1:0] ph;
  logic          cell_lvl;
  logic          nrzi_ref;

  wire edge_seen = rx_in ^ rx_q;
  wire anchor    = edge_seen && (!locked || ph >= MID_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q     <= 1'b1;
      locked   <= 1'b0;
      ph       <= '0;
      cell_lvl <= 1'b1;
      nrzi_ref <= 1'b1;
      rx_valid <= 1'b0;
      rx_data  <= 1'b0;
      rx_viol  <= 1'b0;
    end else begin
      rx_q     <= rx_in;
      rx_valid <= 1'b0;
      rx_viol  <= 1'b0;
      if (!biphase) begin
        locked <= 1'b0;
        ph     <= '0;
        if (rx_stb) begin
          rx_valid <= 1'b1;
          rx_data  <= is_nrzi ? (rx_in == nrzi_ref) : rx_in;
          nrzi_ref <= rx_in;
        end
      end else if (anchor) begin
        locked   <= 1'b1;
        ph       <= CW'(1);
        cell_lvl <= rx_in;
        if (is_man) begin
          rx_valid <= 1'b1;
          rx_data  <= ~rx_in;
        end
      end else if (locked) begin
        if (ph == TMO_C) begin
          rx_viol <= 1'b1;
          locked  <= 1'b0;
          ph      <= '0;
        end else begin
          ph <= ph + 1'b1;
          if (is_fm && ph == MID_C) begin
            rx_valid <= 1'b1;
            rx_data  <= is_fm1 ? (rx_in != cell_lvl) : (rx_in == cell_lvl);
          end
        end
      end
    end
  end

  // R1
  nrz_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_NRZ && tx_stb) |=> tx_line == $past(tx_bit));
  // R2
  nrzi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_nrzi && tx_stb && tx_bit) |=> tx_line == $past(tx_line));
  // R3
  fm_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_fm && tx_stb) |=> tx_line != $past(tx_line));
  // R5
  man_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_man && tx_stb) |=> tx_line == $past(tx_bit));
  // R9
  valid_viol_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && rx_viol));
  // R10
  level_valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !biphase) |-> $past(rx_stb));
endmodule

// File: tb/sim_line_codec.sv
module sim_line_codec;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic tx_stb = 1'b0, tx_bit = 1'b0, rx_stb = 1'b0;
  logic loop_en = 1'b1, rx_force = 1'b1;
  logic tx_line, rx_valid, rx_data, rx_viol;
  wire  rx_in = loop_en ? tx_line : rx_force;

  int n_tests = 0, n_fail = 0;
  int rcnt = 0, vcnt = 0;
  logic rcv [0:255];
  logic sent [0:255];
  logic exp_lvl;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  line_codec u0 (.clk(clk), .rst_n(rst_n), .mode(mode), .tx_stb(tx_stb), .tx_bit(tx_bit),
                 .tx_line(tx_line), .rx_in(rx_in), .rx_stb(rx_stb), .rx_valid(rx_valid),
                 .rx_data(rx_data), .rx_viol(rx_viol));

  always @(negedge clk) if (rst_n) begin
    if (rx_valid && rcnt < 256) begin rcv[rcnt] = rx_data; rcnt++; end
    if (rx_viol) vcnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (mode %0d)", req, act, exp, mode);
    end
  endtask

  function automatic string tag(input logic [2:0] m);
    case (m)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R1";
    endcase
  endfunction

  function automatic bit is_bi(input logic [2:0] m);
    return m == 3'd2 || m == 3'd3 || m == 3'd4;
  endfunction

  function automatic logic first_lvl(input logic [2:0] m, input logic b, input logic prev);
    case (m)
      3'd1: return b ? prev : ~prev;
      3'd2, 3'd3: return ~prev;
      default: return b;
    endcase
  endfunction

  function automatic logic second_lvl(input logic [2:0] m, input logic b, input logic f);
    case (m)
      3'd2: return b ? f : ~f;
      3'd3: return b ? ~f : f;
      3'd4: return ~b;
      default: return f;
    endcase
  endfunction

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; tx_stb = 1'b0; rx_stb = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rcnt = 0; vcnt = 0; exp_lvl = 1'b1;
  endtask

  // entry and exit at a negedge; strobe edge is the next posedge
  task automatic send_cell(input logic b);
    logic f, s;
    f = first_lvl(mode, b, exp_lvl);
    s = second_lvl(mode, b, f);
    tx_stb = 1'b1; tx_bit = b;
    @(negedge clk);
    tx_stb = 1'b0;
    chk(tx_line == f, {tag(mode), "/R7 first half at strobe"}, tx_line, f);
    repeat (7) @(negedge clk);
    chk(tx_line == f, {tag(mode), "/R7 first half before mid"}, tx_line, f);
    if (!is_bi(mode)) rx_stb = 1'b1;
    @(negedge clk);
    rx_stb = 1'b0;
    chk(tx_line == s, {tag(mode), "/R7 second half at mid"}, tx_line, s);
    repeat (7) @(negedge clk);
    exp_lvl = s;
  endtask

  task automatic run_loop(input logic [2:0] m, input int n);
    int bad;
    do_reset(m);
    loop_en = 1'b1;
    chk(tx_line == 1'b1, "R6 idle high after reset", tx_line, 1);
    for (int i = 0; i < n; i++) begin
      sent[i] = (i == 0 && m == 3'd4) ? 1'b1 : 1'($urandom % 2);
      send_cell(sent[i]);
    end
    repeat (40) @(negedge clk);
    chk(tx_line == exp_lvl, "R6 line holds without strobe", tx_line, exp_lvl);
    chk(rcnt == n, {tag(m), " decoded bit count"}, rcnt, n);
    bad = 0;
    for (int i = 0; i < n && i < rcnt; i++) if (rcv[i] !== sent[i]) bad++;
    chk(bad == 0, {tag(m), " decoded bits match"}, bad, 0);
    chk(vcnt == (is_bi(m) ? 1 : 0), "R9 one flag after stream ends", vcnt, is_bi(m) ? 1 : 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    exp_lvl = 1'b1;
    @(negedge clk);
    chk(tx_line == 1'b1 && rx_valid == 1'b0 && rx_viol == 1'b0, "R6 reset state",
        {tx_line, rx_valid, rx_viol}, 3'b100);

    run_loop(3'd0, 40);
    run_loop(3'd1, 40);
    run_loop(3'd2, 40);
    run_loop(3'd3, 40);
    run_loop(3'd4, 40);
    run_loop(3'd5, 16);

    // R2 directed: all zeros toggle every cell, all ones hold
    do_reset(3'd1); loop_en = 1'b1;
    for (int i = 0; i < 4; i++) send_cell(1'b0);
    for (int i = 0; i < 4; i++) send_cell(1'b1);
    chk(rcnt == 8 && rcv[0] == 1'b0 && rcv[7] == 1'b1, "R2 run of zeros then ones",
        rcnt, 8);

    // R10: biphase ignores rx_stb; R9 unlocked never flags
    do_reset(3'd2); loop_en = 1'b0; rx_force = 1'b1;
    for (int i = 0; i < 5; i++) begin
      rx_stb = 1'b1; @(negedge clk); rx_stb = 1'b0; repeat (30) @(negedge clk);
    end
    chk(rcnt == 0, "R10 rx_stb ignored in FM0", rcnt, 0);
    chk(vcnt == 0, "R9 no flag while unlocked", vcnt, 0);

    // R9/R8 timing: one edge then silence, FM1
    do_reset(3'd3); loop_en = 1'b0; rx_force = 1'b1;
    repeat (3) @(negedge clk);
    rx_force = 1'b0;
    repeat (13) @(negedge clk);
    chk(rx_valid == 1'b1 && rx_data == 1'b0, "R8 FM1 sample at count 12",
        {rx_valid, rx_data}, 2'b10);
    repeat (7) @(negedge clk);
    chk(rx_viol == 1'b0, "R9 no flag before timeout", rx_viol, 0);
    @(negedge clk);
    chk(rx_viol == 1'b1 && rx_valid == 1'b0, "R9 flag at count OVS+4", rx_viol, 1);
    @(negedge clk);
    chk(rx_viol == 1'b0, "R9 flag is one clock", rx_viol, 0);

    // R8: mid edge does not resync, early cell edge does (FM0)
    do_reset(3'd2); loop_en = 1'b0; rx_force = 1'b1;
    repeat (2) @(negedge clk);
    rx_force = 1'b0;
    repeat (8) @(negedge clk);
    rx_force = 1'b1;
    repeat (6) @(negedge clk);
    rx_force = 1'b0;
    repeat (40) @(negedge clk);
    chk(rcnt == 2, "R8 two cells decoded", rcnt, 2);
    chk(rcnt == 2 && rcv[0] == 1'b0 && rcv[1] == 1'b1, "R8 mid edge kept, early edge taken",
        {rcv[0], rcv[1]}, 2'b01);
    chk(vcnt == 1, "R9 single flag after forced cells", vcnt, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule